// File: doc/BRIEF.md
# PLL Lock Timer and Clock Switch

This block decides when the output of a phase-locked loop may safely serve as the system clock. A register interface writes a crystal-select code, a PLL power-down bit and a request to run from the PLL. Whenever the PLL has to settle again, a down counter clocked by the main oscillator measures a lock window. Until that window has passed, the effective clock select keeps the system on the oscillator, even when software enabled the PLL and asked for it in the same write.

Two kinds of write force a relock. The first changes the crystal code to a different value while the PLL stays powered. The second takes the PLL out of power-down. A write that stores the crystal code already held starts nothing. The length of the window depends on the crystal code: crystal codes at or below a threshold get the short window, and higher codes get the long one. When the window ends, the block raises a ready flag and a sticky raw lock status bit. It also produces an interrupt from that status bit and a mask.

Top module: `pll_lock_ctrl`

## Requirements
- R1: After synchronous reset, `lock_ready`, `lock_raw`, `lock_irq` and `sysclk_pll_sel` are 0, the PLL is held in power-down, the stored crystal code is 0 and the PLL request is off.
- R2: A write (`cfg_we`=1, `cfg_pwrdn`=0) whose `cfg_xtal` differs from the stored code clears `lock_ready` and `sysclk_pll_sel` at the edge that captures it, and starts a relock window.
- R3: A write with `cfg_pwrdn`=0 that repeats the stored crystal code, with the PLL already powered, leaves `lock_ready` and a running window untouched.
- R4: A write with `cfg_pwrdn`=0 while the PLL is powered down starts a relock window, including when the crystal code is unchanged.
- R5: A window is 0x1200 cycles when the new crystal code is 0x0F or lower and 0x2400 cycles when it is above 0x0F. `lock_ready` rises exactly that many rising edges after the edge that captured the starting write.
- R6: `sysclk_pll_sel` equals PLL request AND not powered down AND `lock_ready`, updated at the same edge as those three. A one-step write that powers up the PLL and requests it keeps the select at 0 until `lock_ready` rises.
- R7: `lock_raw` is set at the edge where `lock_ready` rises and stays set until it is cleared.
- R8: A relock trigger during a running window reloads the counter with the window of the new crystal code and keeps `lock_ready` low.
- R9: `irq_clr`=1 clears `lock_raw` at the next edge, unless a window ends at that same edge, in which case the set wins. `lock_irq` is the registered AND of `lock_raw` and `irq_mask`, one edge behind `lock_raw`.
- R10: A write with `cfg_pwrdn`=1 clears `lock_ready` and `sysclk_pll_sel` and stops the counter at its capturing edge. While the PLL is powered down, crystal changes start no window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock; runs the counter and all registers |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_xtal | input | XTAL_W | Crystal-select code |
| cfg_pwrdn | input | 1 | 1 puts the PLL into power-down, 0 runs it normally |
| cfg_use_pll | input | 1 | Software request to clock the system from the PLL |
| irq_clr | input | 1 | Write-one-to-clear for the raw lock status |
| irq_mask | input | 1 | Enables the raw lock status onto the interrupt |
| lock_ready | output | 1 | PLL lock window has elapsed since the last relock trigger |
| lock_raw | output | 1 | Sticky raw lock status |
| lock_irq | output | 1 | Masked lock interrupt |
| sysclk_pll_sel | output | 1 | Effective clock select: 1 selects the PLL, 0 the oscillator |

## Verification
Each result has a fixed due cycle counted from the rising edge that captures the write. The drop of `lock_ready` and `sysclk_pll_sel` on a trigger or power-down is visible right after that edge. `lock_ready`, `lock_raw` and a pending select rise exactly N edges later. `lock_irq` follows `lock_raw` or `irq_mask` one edge later. The bench drives and samples on falling edges. For every window it checks that ready is still low on the falling edge before edge N and high on the one after it. For a retrigger or a same-value rewrite, it recomputes the remaining count from the edge that started the window that is expected to count.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  typedef struct packed {
    logic start;  // begin or restart a lock window
    logic stop;   // abandon the window, PLL going to power-down
  } relock_ev_t;

  function automatic logic [31:0] lock_len(input logic [31:0] xtal,
                                           input logic [31:0] thresh,
                                           input logic [31:0] short_len,
                                           input logic [31:0] long_len);
    return (xtal > thresh) ? long_len : short_len;
  endfunction

endpackage

// File: rtl/pll_cfg_track.sv
module pll_cfg_track
  import pll_lock_pkg::*;
#(
  parameter int XTAL_W = 5,
  parameter logic [XTAL_W-1:0] XTAL_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [XTAL_W-1:0] xtal,
  input  logic              pwrdn,
  input  logic              use_pll,
  output relock_ev_t        ev,
  output logic              pwrdn_d,
  output logic              use_d
);

  logic [XTAL_W-1:0] xtal_q;
  logic              pwrdn_q;
  logic              use_q;

  // Next values of the shadow fields, shared with the select logic.
  always_comb begin
    pwrdn_d  = we ? pwrdn   : pwrdn_q;
    use_d    = we ? use_pll : use_q;
    ev.stop  = we && pwrdn;
    ev.start = we && !pwrdn && ((xtal != xtal_q) || pwrdn_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q  <= XTAL_RST;
      pwrdn_q <= 1'b1;
      use_q   <= 1'b0;
    end else begin
      if (we) xtal_q <= xtal;
      pwrdn_q <= pwrdn_d;
      use_q   <= use_d;
    end
  end

endmodule

// File: rtl/pll_lock_count.sv
module pll_lock_count
  import pll_lock_pkg::*;
#(
  parameter int XTAL_W = 5,
  parameter int CNT_W  = 14,
  parameter logic [31:0] THRESH    = 32'h0F,
  parameter logic [31:0] SHORT_LEN = 32'h1200,
  parameter logic [31:0] LONG_LEN  = 32'h2400
) (
  input  logic              clk,
  input  logic              rst,
  input  relock_ev_t        ev,
  input  logic [XTAL_W-1:0] xtal,
  output logic              ready,
  output logic              ready_d,
  output logic              done_d
);

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             busy, busy_d;
  logic [31:0]      len_full;
  logic [CNT_W-1:0] load;

  always_comb begin
    len_full = lock_len(32'(xtal), THRESH, SHORT_LEN, LONG_LEN);
    load     = len_full[CNT_W-1:0];
  end

  always_comb begin
    cnt_d   = cnt;
    busy_d  = busy;
    ready_d = ready;
    done_d  = 1'b0;
    if (ev.stop) begin
      cnt_d   = '0;
      busy_d  = 1'b0;
      ready_d = 1'b0;
    end else if (ev.start) begin
      cnt_d   = load;
      busy_d  = 1'b1;
      ready_d = 1'b0;
    end else if (busy) begin
      cnt_d = cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        busy_d  = 1'b0;
        ready_d = 1'b1;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      busy  <= 1'b0;
      ready <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      busy  <= busy_d;
      ready <= ready_d;
    end
  end

endmodule

// File: rtl/pll_lock_stat.sv
module pll_lock_stat (
  input  logic clk,
  input  logic rst,
  input  logic done_d,
  input  logic ready_d,
  input  logic use_d,
  input  logic pwrdn_d,
  input  logic clr,
  input  logic mask,
  output logic raw,
  output logic irq,
  output logic sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw <= 1'b0;
      irq <= 1'b0;
      sel <= 1'b0;
    end else begin
      if (done_d)   raw <= 1'b1;
      else if (clr) raw <= 1'b0;
      irq <= raw & mask;
      sel <= use_d & ~pwrdn_d & ready_d;
    end
  end

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
  import pll_lock_pkg::*;
#(
  parameter int XTAL_W = 5,
  parameter logic [XTAL_W-1:0] XTAL_RST = '0,
  parameter logic [31:0] THRESH    = 32'h0F,
  parameter logic [31:0] SHORT_LEN = 32'h1200,
  parameter logic [31:0] LONG_LEN  = 32'h2400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [XTAL_W-1:0] cfg_xtal,
  input  logic              cfg_pwrdn,
  input  logic              cfg_use_pll,
  input  logic              irq_clr,
  input  logic              irq_mask,
  output logic              lock_ready,
  output logic              lock_raw,
  output logic              lock_irq,
  output logic              sysclk_pll_sel
);

  localparam logic [31:0] MAX_LEN = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  relock_ev_t ev;
  logic       pwrdn_d, use_d, ready_d, done_d;

  pll_cfg_track #(.XTAL_W(XTAL_W), .XTAL_RST(XTAL_RST)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .xtal(cfg_xtal), .pwrdn(cfg_pwrdn),
    .use_pll(cfg_use_pll), .ev(ev), .pwrdn_d(pwrdn_d), .use_d(use_d)
  );

  pll_lock_count #(
    .XTAL_W(XTAL_W), .CNT_W(CNT_W), .THRESH(THRESH),
    .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
  ) u_cnt (
    .clk(clk), .rst(rst), .ev(ev), .xtal(cfg_xtal),
    .ready(lock_ready), .ready_d(ready_d), .done_d(done_d)
  );

  pll_lock_stat u_stat (
    .clk(clk), .rst(rst), .done_d(done_d), .ready_d(ready_d), .use_d(use_d),
    .pwrdn_d(pwrdn_d), .clr(irq_clr), .mask(irq_mask),
    .raw(lock_raw), .irq(lock_irq), .sel(sysclk_pll_sel)
  );

endmodule

// File: rtl/pll_lock_chk.sv
module pll_lock_chk #(
  parameter int XTAL_W = 5,
  parameter logic [XTAL_W-1:0] XTAL_RST = '0,
  parameter logic [31:0] THRESH    = 32'h0F,
  parameter logic [31:0] SHORT_LEN = 32'h1200,
  parameter logic [31:0] LONG_LEN  = 32'h2400
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [XTAL_W-1:0] cfg_xtal,
  input logic              cfg_pwrdn,
  input logic              irq_mask,
  input logic              lock_ready,
  input logic              lock_raw,
  input logic              lock_irq,
  input logic              sysclk_pll_sel
);

  logic [XTAL_W-1:0] xt_sh;
  logic              pd_sh;
  logic [31:0]       elapsed, expect_len;
  logic              trig;

  assign trig = cfg_we && !cfg_pwrdn && ((cfg_xtal != xt_sh) || pd_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      xt_sh      <= XTAL_RST;
      pd_sh      <= 1'b1;
      elapsed    <= '0;
      expect_len <= SHORT_LEN;
    end else begin
      if (cfg_we) begin
        xt_sh <= cfg_xtal;
        pd_sh <= cfg_pwrdn;
      end
      if (trig) begin
        elapsed    <= '0;
        expect_len <= (32'(cfg_xtal) > THRESH) ? LONG_LEN : SHORT_LEN;
      end else if (elapsed != 32'hFFFF_FFFF) begin
        elapsed <= elapsed + 1;
      end
    end
  end

  // R6
  sel_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
    sysclk_pll_sel |-> lock_ready);

  // R10
  pwrdn_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_pwrdn) |=> (!lock_ready && !sysclk_pll_sel));

  // R3
  same_xtal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_pwrdn && !pd_sh && cfg_xtal == xt_sh && lock_ready) |=> lock_ready);

  // R2
  relock_drop_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> (!lock_ready && !sysclk_pll_sel));

  // R7
  raw_on_ready_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_ready) |-> lock_raw);

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_raw && irq_mask) |=> lock_irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_raw |=> !lock_irq);

  // R5
  lock_len_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_ready) |-> (elapsed == expect_len));

endmodule

bind pll_lock_ctrl pll_lock_chk #(
  .XTAL_W(XTAL_W), .XTAL_RST(XTAL_RST), .THRESH(THRESH),
  .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)
) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_xtal(cfg_xtal),
  .cfg_pwrdn(cfg_pwrdn), .irq_mask(irq_mask), .lock_ready(lock_ready),
  .lock_raw(lock_raw), .lock_irq(lock_irq), .sysclk_pll_sel(sysclk_pll_sel)
);

// File: tb/test_pll_lock_ctrl.sv
module test_pll_lock_ctrl;

  localparam int SHORT = 32'h1200;
  localparam int LONG  = 32'h2400;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_xtal = '0;
  logic       cfg_pwrdn = 1'b1;
  logic       cfg_use_pll = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq_mask = 1'b0;
  logic       lock_ready, lock_raw, lock_irq, sysclk_pll_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pll_lock_ctrl i_pll_lock_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_xtal(cfg_xtal),
    .cfg_pwrdn(cfg_pwrdn), .cfg_use_pll(cfg_use_pll), .irq_clr(irq_clr),
    .irq_mask(irq_mask), .lock_ready(lock_ready), .lock_raw(lock_raw),
    .lock_irq(lock_irq), .sysclk_pll_sel(sysclk_pll_sel)
  );

  function automatic int win(input int x);
    return (x > 15) ? LONG : SHORT;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives one write at a falling edge; returns at the falling edge after the capture.
  task automatic wr(input int x, input bit pd, input bit use_pll);
    cfg_we      = 1'b1;
    cfg_xtal    = 5'(x);
    cfg_pwrdn   = pd;
    cfg_use_pll = use_pll;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // rem = edges still needed before ready; called on a falling edge.
  task automatic expect_ready(input int rem, input string req);
    repeat (rem - 1) @(negedge clk);
    chk(lock_ready == 1'b0, req, "ready one edge early", int'(lock_ready), 0);
    chk(sysclk_pll_sel == 1'b0, "R6", "select before lock", int'(sysclk_pll_sel), 0);
    @(negedge clk);
    chk(lock_ready == 1'b1, req, "ready at window end", int'(lock_ready), 1);
    chk(lock_raw == 1'b1, "R7", "raw at window end", int'(lock_raw), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!lock_ready, "R1", "ready after reset", int'(lock_ready), 0);
    chk(!lock_raw, "R1", "raw after reset", int'(lock_raw), 0);
    chk(!lock_irq, "R1", "irq after reset", int'(lock_irq), 0);
    chk(!sysclk_pll_sel, "R1", "select after reset", int'(sysclk_pll_sel), 0);

    // R4 R6: one-step power-up and PLL request, boundary code 0x0F
    wr(15, 1'b0, 1'b1);
    chk(!sysclk_pll_sel, "R6", "select right after one-step write", int'(sysclk_pll_sel), 0);
    expect_ready(win(15), "R5");
    chk(sysclk_pll_sel, "R6", "select moves to PLL", int'(sysclk_pll_sel), 1);
    chk(!lock_irq, "R9", "irq masked", int'(lock_irq), 0);

    // R9 mask and clear
    irq_mask = 1'b1;
    @(negedge clk);
    chk(lock_irq, "R9", "irq after unmask", int'(lock_irq), 1);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(!lock_raw, "R9", "raw after clear", int'(lock_raw), 0);
    @(negedge clk);
    chk(!lock_irq, "R9", "irq after clear", int'(lock_irq), 0);

    // R3 same value rewrite while locked
    wr(15, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    chk(lock_ready, "R3", "ready after same-value write", int'(lock_ready), 1);
    chk(!lock_raw, "R3", "no new lock event", int'(lock_raw), 0);

    // R2 R5: change to 0x10, long window
    wr(16, 1'b0, 1'b1);
    chk(!lock_ready, "R2", "ready drops on change", int'(lock_ready), 0);
    chk(!sysclk_pll_sel, "R2", "select drops on change", int'(sysclk_pll_sel), 0);
    expect_ready(win(16), "R5");

    // R8 retrigger long then short mid-window
    wr(17, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    wr(14, 1'b0, 1'b1);
    expect_ready(win(14), "R8");

    // R3 same-value rewrite during a window does not reload
    wr(5, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    wr(5, 1'b0, 1'b1);
    expect_ready(win(5) - 51, "R3");

    // R10 power-down
    wr(31, 1'b1, 1'b1);
    chk(!lock_ready, "R10", "ready drops on power-down", int'(lock_ready), 0);
    chk(!sysclk_pll_sel, "R10", "select drops on power-down", int'(sysclk_pll_sel), 0);
    wr(30, 1'b1, 1'b1);
    repeat (LONG + 20) @(negedge clk);
    chk(!lock_ready, "R10", "no window while powered down", int'(lock_ready), 0);

    // R4 power-up with unchanged code, long window
    wr(30, 1'b0, 1'b1);
    expect_ready(win(30), "R4");

    // R6 request off and on while locked
    wr(30, 1'b0, 1'b0);
    chk(!sysclk_pll_sel, "R6", "select off with request off", int'(sysclk_pll_sel), 0);
    chk(lock_ready, "R6", "ready kept with request off", int'(lock_ready), 1);
    wr(30, 1'b0, 1'b1);
    chk(sysclk_pll_sel, "R6", "select on with request on", int'(sysclk_pll_sel), 1);

    // R5 smallest code, short window
    wr(0, 1'b0, 1'b1);
    expect_ready(win(0), "R5");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule